// File: doc/BRIEF.md
# SPI Serial Flash Command Engine

This block is a register-mapped SPI master for talking to a serial flash device. Software programs a 24-bit flash address into one register. It then writes a command byte, a capture selector and a start bit into a control register. The engine drives a single-lane SPI frame made of the command byte, the three address bytes and zero filler bytes. During the same frame it receives bytes on MISO and stores chosen byte positions in a read-only result register.

The capture selector sets both the frame length and the byte position or positions that are kept. Some selector codes keep a single byte. Others keep a four-byte window and store it so that the first byte received sits in the lowest lane. In chip-select-hold mode each transaction moves exactly one byte and chip select stays low afterwards. Software can therefore build a longer command by writing bytes one at a time through the command field. A later control write with hold and start both clear releases chip select.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: Registers are decoded from bus_addr[3:2]: 0x0 is control, 0x4 is flash address (32-bit read/write) and 0x8 is the result (read-only; writes have no effect). Control reads back as command in [7:0], selector in [10:8], hold in [12] and busy in [31], with all other bits zero. bus_rdata is valid on the cycle after bus_rd, and all registers read as zero after reset.
- R2: A control write with bit 31 set, made while idle, starts a transaction. Bit 31 reads 1 from the following cycle until the transaction ends, and then reads 0 without any software action.
- R3: SPI mode 0 is used. SCK is low while idle, MOSI changes only while SCK is low, MISO is sampled on the rising SCK edge, and within a transaction SCK has a period of CLK_DIV system clocks.
- R4: Frame bytes go out MSB first. Byte 1 is the command byte, bytes 2, 3 and 4 are address bits [23:16], [15:8] and [7:0], and every later byte is 0x00.
- R5: With hold clear, the frame length in bytes for selectors 0..7 is 1, 2, 4, 5, 8, 12, 3 and 9. Chip select (active low) goes high when the last byte completes.
- R6: Selectors 0, 1, 6, 2 and 3 store received byte 1, 2, 3, 4 and 5 respectively into result[7:0], with result[31:8] zero.
- R7: Selectors 4, 5 and 7 store received bytes 5..8, 9..12 and 6..9. The earliest byte of the window goes to result[7:0] and the latest to result[31:24].
- R8: With hold set, a transaction moves exactly one byte whatever the selector. The received byte goes to result[7:0] (upper bits zero) and chip select stays low after the transaction.
- R9: An idle control write with bit 31 clear and bit 12 clear drives chip select high. The same write with bit 12 set leaves it low.
- R10: Writes to the control and address registers while busy have no effect on the stored values or on the frame in progress.
- R11: Chip select is low for the whole of every transaction, and SCK is never high while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bound checker watches the SPI line discipline on every cycle. It checks that SCK stays low while idle, that MOSI holds still while SCK is high, and that chip select stays low through each transaction and never lets SCK rise while it is high. It also checks that control and address writes made while busy leave the stored values untouched, and that chip select ends in the right state for hold and non-hold frames. The per-selector frame lengths, the transmitted byte sequence, the byte position or swapped window that reaches the result register, and the byte-at-a-time sequence under hold can only be shown by the bench's scenarios. In those scenarios a modelled flash replies with a known byte pattern.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int REG_W = 32;
  localparam int POS_W = 4;
  localparam int CTRL_START_BIT = 31;
  localparam int CTRL_HOLD_BIT  = 12;

  // Last byte position of a non-hold frame for each capture selector.
  function automatic logic [POS_W-1:0] frame_last(input logic [2:0] sel);
    case (sel)
      3'd0:    frame_last = 4'd1;
      3'd1:    frame_last = 4'd2;
      3'd2:    frame_last = 4'd4;
      3'd3:    frame_last = 4'd5;
      3'd4:    frame_last = 4'd8;
      3'd5:    frame_last = 4'd12;
      3'd6:    frame_last = 4'd3;
      default: frame_last = 4'd9;
    endcase
  endfunction

  // First byte position kept in the result register.
  function automatic logic [POS_W-1:0] cap_first(input logic [2:0] sel);
    case (sel)
      3'd0:    cap_first = 4'd1;
      3'd1:    cap_first = 4'd2;
      3'd2:    cap_first = 4'd4;
      3'd3:    cap_first = 4'd5;
      3'd4:    cap_first = 4'd5;
      3'd5:    cap_first = 4'd9;
      3'd6:    cap_first = 4'd3;
      default: cap_first = 4'd6;
    endcase
  endfunction

  // Selectors that keep a four-byte window rather than one byte.
  function automatic logic cap_wide(input logic [2:0] sel);
    cap_wide = (sel == 3'd4) || (sel == 3'd5) || (sel == 3'd7);
  endfunction
endpackage

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
  import spi_eng_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              busy,
  input  logic [REG_W-1:0]  result,
  output logic              launch,
  output logic              release_cs,
  output logic [7:0]        opcode,
  output logic [2:0]        sel,
  output logic              hold,
  output logic [23:0]       flash_addr
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word_idx;
  logic              hit_ctrl, hit_addr, hit_data;
  logic              ctrl_wr, addr_wr;
  logic [REG_W-1:0]  addr_q;
  logic [7:0]        opcode_q;
  logic [2:0]        sel_q;
  logic              hold_q;
  logic [REG_W-1:0]  rdata_q;
  logic [REG_W-1:0]  ctrl_view;

  assign word_idx = addr[ADDR_W-1:2];
  assign hit_ctrl = (word_idx == WORD_W'(0));
  assign hit_addr = (word_idx == WORD_W'(1));
  assign hit_data = (word_idx == WORD_W'(2));

  assign ctrl_wr    = wr_en && hit_ctrl && !busy;
  assign addr_wr    = wr_en && hit_addr && !busy;
  assign launch     = ctrl_wr && wdata[CTRL_START_BIT];
  assign release_cs = ctrl_wr && !wdata[CTRL_START_BIT] && !wdata[CTRL_HOLD_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode_q <= '0;
      sel_q    <= '0;
      hold_q   <= 1'b0;
      addr_q   <= '0;
    end else begin
      if (ctrl_wr) begin
        opcode_q <= wdata[7:0];
        sel_q    <= wdata[10:8];
        hold_q   <= wdata[CTRL_HOLD_BIT];
      end
      if (addr_wr) begin
        addr_q <= wdata;
      end
    end
  end

  assign ctrl_view = {busy, 18'd0, hold_q, 1'b0, sel_q, opcode_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      if (hit_ctrl)      rdata_q <= ctrl_view;
      else if (hit_addr) rdata_q <= addr_q;
      else if (hit_data) rdata_q <= result;
      else               rdata_q <= '0;
    end
  end

  assign rdata      = rdata_q;
  assign opcode     = opcode_q;
  assign sel        = sel_q;
  assign hold       = hold_q;
  assign flash_addr = addr_q[23:0];
endmodule

// File: rtl/spi_eng_sck_gen.sv
module spi_eng_sck_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (at_end)  cnt_q <= '0;
    else              cnt_q <= cnt_q + CW'(1);
  end

  assign tick = run && at_end;
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_byte,
  input  logic         shift,
  input  logic         sample,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_byte
);
  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst)        tx_q <= '0;
    else if (load)  tx_q <= load_byte;
    else if (shift) tx_q <= {tx_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst)         rx_q <= '0;
    else if (sample) rx_q <= {rx_q[W-2:0], miso};
  end

  assign mosi    = tx_q[W-1];
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_eng_capture.sv
module spi_eng_capture
  import spi_eng_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             byte_done,
  input  logic             hold,
  input  logic [2:0]       sel,
  input  logic [POS_W-1:0] pos,
  input  logic [7:0]       rx_byte,
  output logic [REG_W-1:0] result
);
  localparam int LANES = REG_W / 8;

  logic [POS_W-1:0] first, last, slot;
  logic             wide, in_win;

  assign first  = cap_first(sel);
  assign last   = frame_last(sel);
  assign wide   = cap_wide(sel);
  assign in_win = (pos >= first) && (pos <= last);
  assign slot   = pos - first;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        lane_q <= '0;
      end else if (byte_done) begin
        if (hold) begin
          lane_q <= (g == 0) ? rx_byte : 8'h00;
        end else if (wide) begin
          if (in_win && (slot == POS_W'(g))) lane_q <= rx_byte;
        end else if (pos == first) begin
          lane_q <= (g == 0) ? rx_byte : 8'h00;
        end
      end
    end
    assign result[g*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic             launch, release_cs;
  logic [7:0]       opcode_w;
  logic [2:0]       sel_w;
  logic             hold_w;
  logic [23:0]      faddr_w;
  logic [REG_W-1:0] result_w;
  logic [7:0]       rx_byte_w;
  logic             tick;

  logic             busy_q, sck_q, cs_n_q;
  logic [2:0]       bit_q;
  logic [POS_W-1:0] pos_q;

  logic [POS_W-1:0] end_pos, next_pos;
  logic             rise_ev, fall_ev, byte_end, frame_end;
  logic             ld_en, sh_en;
  logic [7:0]       ld_byte, next_byte;

  spi_eng_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (bus_wr),
    .rd_en      (bus_rd),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .rdata      (bus_rdata),
    .busy       (busy_q),
    .result     (result_w),
    .launch     (launch),
    .release_cs (release_cs),
    .opcode     (opcode_w),
    .sel        (sel_w),
    .hold       (hold_w),
    .flash_addr (faddr_w)
  );

  spi_eng_sck_gen #(.CLK_DIV(CLK_DIV)) u_sck (
    .clk  (clk),
    .rst  (rst),
    .run  (busy_q),
    .tick (tick)
  );

  assign end_pos   = hold_w ? POS_W'(1) : frame_last(sel_w);
  assign next_pos  = pos_q + POS_W'(1);
  assign rise_ev   = busy_q && tick && !sck_q;
  assign fall_ev   = busy_q && tick && sck_q;
  assign byte_end  = fall_ev && (bit_q == 3'd7);
  assign frame_end = byte_end && (pos_q == end_pos);

  always_comb begin
    case (next_pos)
      4'd2:    next_byte = faddr_w[23:16];
      4'd3:    next_byte = faddr_w[15:8];
      4'd4:    next_byte = faddr_w[7:0];
      default: next_byte = 8'h00;
    endcase
  end

  assign ld_en   = launch || (byte_end && !frame_end);
  assign ld_byte = launch ? bus_wdata[7:0] : next_byte;
  assign sh_en   = fall_ev && (bit_q != 3'd7);

  spi_eng_shifter #(.W(8)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (ld_en),
    .load_byte (ld_byte),
    .shift     (sh_en),
    .sample    (rise_ev),
    .miso      (spi_miso),
    .mosi      (spi_mosi),
    .rx_byte   (rx_byte_w)
  );

  spi_eng_capture u_cap (
    .clk       (clk),
    .rst       (rst),
    .clear     (launch),
    .byte_done (byte_end),
    .hold      (hold_w),
    .sel       (sel_w),
    .pos       (pos_q),
    .rx_byte   (rx_byte_w),
    .result    (result_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      cs_n_q <= 1'b1;
      bit_q  <= '0;
      pos_q  <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      sck_q  <= 1'b0;
      cs_n_q <= 1'b0;
      bit_q  <= '0;
      pos_q  <= POS_W'(1);
    end else if (release_cs) begin
      cs_n_q <= 1'b1;
    end else if (rise_ev) begin
      sck_q <= 1'b1;
    end else if (fall_ev) begin
      sck_q <= 1'b0;
      bit_q <= bit_q + 3'd1;
      if (frame_end) begin
        busy_q <= 1'b0;
        cs_n_q <= !hold_w;
      end else if (byte_end) begin
        pos_q <= next_pos;
      end
    end
  end

  assign spi_sck  = sck_q;
  assign spi_cs_n = cs_n_q;
endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              busy,
  input logic              hold,
  input logic              spi_sck,
  input logic              spi_cs_n,
  input logic              spi_mosi,
  input logic [11:0]       cfg,
  input logic [23:0]       faddr
);
  logic wr_ctrl, wr_addr;
  assign wr_ctrl = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(0));
  assign wr_addr = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !spi_sck); // R3
  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> $stable(spi_mosi)); // R3
  AST_CS_LOW_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !spi_cs_n); // R11
  AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> !spi_cs_n); // R11
  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_ctrl) |=> $stable(cfg)); // R10
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_addr) |=> $stable(faddr)); // R10
  AST_END_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !hold) |-> spi_cs_n); // R5
  AST_END_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && hold) |-> !spi_cs_n); // R8
endmodule

bind spi_flash_cmd_engine spi_eng_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .busy     (busy_q),
  .hold     (hold_w),
  .spi_sck  (spi_sck),
  .spi_cs_n (spi_cs_n),
  .spi_mosi (spi_mosi),
  .cfg      ({opcode_w, sel_w, hold_w}),
  .faddr    (faddr_w)
);

// File: tb/spi_flash_cmd_engine_tb.sv
module spi_flash_cmd_engine_tb;
  localparam int CLK_DIV = 4;
  localparam int ADDR_W  = 4;
  localparam time TCLK   = 20ns;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              spi_sck, spi_cs_n, spi_mosi, spi_miso;

  always #10ns clk = ~clk;

  spi_flash_cmd_engine #(.CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_checks = 0;
  int n_fails  = 0;

  // Flash model: replies byte k (0-based since chip select fell) = pat(k).
  logic [7:0] seed = 8'h00;
  int         bitcnt = 0;
  int         rises = 0;
  int         period_err = 0;
  time        last_rise = 0;
  logic [7:0] mosi_log [16];

  function automatic logic [7:0] pat(input int k, input logic [7:0] s);
    return (s + 8'(k) * 8'h3B) ^ 8'hA5;
  endfunction

  function automatic logic miso_bit(input int b, input logic [7:0] s);
    logic [7:0] v;
    v = pat(b / 8, s);
    return v[7 - (b % 8)];
  endfunction

  assign spi_miso = spi_cs_n ? 1'b0 : miso_bit(bitcnt, seed);

  always @(negedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) bitcnt <= 0;
    else          bitcnt <= bitcnt + 1;
  end

  always @(posedge spi_sck) begin
    mosi_log[(bitcnt / 8) % 16] <= {mosi_log[(bitcnt / 8) % 16][6:0], spi_mosi};
    rises <= rises + 1;
    if ((bitcnt % 8) != 0 && ($time - last_rise) != CLK_DIV * TCLK)
      period_err <= period_err + 1;
    last_rise <= $time;
  end

  // Bench-side model of the selector table.
  function automatic int b_len(input int a);
    case (a)
      0: return 1;  1: return 2;  2: return 4;  3: return 5;
      4: return 8;  5: return 12; 6: return 3;  default: return 9;
    endcase
  endfunction
  function automatic int b_first(input int a);
    case (a)
      0: return 1;  1: return 2;  2: return 4;  3: return 5;
      4: return 5;  5: return 9;  6: return 3;  default: return 6;
    endcase
  endfunction
  function automatic logic [31:0] ctrl_word(input logic st, input logic hd,
                                            input logic [2:0] a, input logic [7:0] op);
    return {st, 18'd0, hd, 1'b0, a, op};
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    v = 32'h8000_0000;
    for (int i = 0; i < 3000 && v[31]; i++) reg_read(4'h0, v);
    chk({tag, " busy clears by itself"}, {31'd0, v[31]}, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 reset cs_n high", {31'd0, spi_cs_n}, 32'd1);
    chk("R3 reset sck low", {31'd0, spi_sck}, 32'd0);
    reg_read(4'h0, v); chk("R1 reset ctrl", v, 32'd0);
    reg_read(4'h4, v); chk("R1 reset addr", v, 32'd0);
    reg_read(4'h8, v); chk("R1 reset data", v, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    reg_write(4'h4, 32'hDEAD_BEEF);
    reg_read(4'h4, v); chk("R1 addr readback", v, 32'hDEAD_BEEF);
    reg_write(4'h8, 32'hFFFF_FFFF);
    reg_read(4'h8, v); chk("R1 data write ignored", v, 32'd0);
    chk("R1 no frame from data write", {31'd0, spi_cs_n}, 32'd1);
  endtask

  task automatic t_select(input int a, input logic [7:0] op,
                          input logic [31:0] fa, input logic [7:0] sd);
    logic [31:0] v, expd;
    int r0, len, f;
    seed = sd;
    len = b_len(a);
    f = b_first(a);
    reg_write(4'h4, fa);
    r0 = rises;
    reg_write(4'h0, ctrl_word(1'b1, 1'b0, 3'(a), op));
    reg_read(4'h0, v);
    chk($sformatf("R2 busy set sel%0d", a), {31'd0, v[31]}, 32'd1);
    wait_idle($sformatf("R2 sel%0d", a));
    chk($sformatf("R5 cs released sel%0d", a), {31'd0, spi_cs_n}, 32'd1);
    chk($sformatf("R5 frame bits sel%0d", a), 32'(rises - r0), 32'(len * 8));
    for (int k = 0; k < len; k++) begin
      logic [7:0] eb;
      case (k)
        0: eb = op; 1: eb = fa[23:16]; 2: eb = fa[15:8]; 3: eb = fa[7:0];
        default: eb = 8'h00;
      endcase
      chk($sformatf("R4 mosi byte%0d sel%0d", k + 1, a), {24'd0, mosi_log[k]}, {24'd0, eb});
    end
    if (a == 4 || a == 5 || a == 7)
      expd = {pat(f + 2, sd), pat(f + 1, sd), pat(f, sd), pat(f - 1, sd)};
    else
      expd = {24'd0, pat(f - 1, sd)};
    reg_read(4'h8, v);
    if (a == 4 || a == 5 || a == 7)
      chk($sformatf("R7 swapped window sel%0d", a), v, expd);
    else
      chk($sformatf("R6 single byte sel%0d", a), v, expd);
    reg_read(4'h0, v);
    chk($sformatf("R1 ctrl fields sel%0d", a), v, ctrl_word(1'b0, 1'b0, 3'(a), op));
  endtask

  task automatic t_busy_writes();
    logic [31:0] v;
    seed = 8'h71;
    reg_write(4'h4, 32'h0012_3456);
    reg_write(4'h0, ctrl_word(1'b1, 1'b0, 3'd5, 8'h0B));
    reg_write(4'h4, 32'h00FE_DCBA);
    reg_write(4'h0, ctrl_word(1'b0, 1'b1, 3'd1, 8'h11));
    reg_write(4'h0, ctrl_word(1'b1, 1'b0, 3'd0, 8'h22));
    wait_idle("R10");
    reg_read(4'h4, v); chk("R10 addr kept while busy", v, 32'h0012_3456);
    reg_read(4'h0, v); chk("R10 ctrl kept while busy", v, ctrl_word(1'b0, 1'b0, 3'd5, 8'h0B));
    chk("R10 frame addr byte2", {24'd0, mosi_log[1]}, 32'h12);
    chk("R10 frame addr byte4", {24'd0, mosi_log[3]}, 32'h56);
    chk("R10 cs released after frame", {31'd0, spi_cs_n}, 32'd1);
    reg_read(4'h8, v);
    chk("R10 result of original frame", v, {pat(11, 8'h71), pat(10, 8'h71), pat(9, 8'h71), pat(8, 8'h71)});
  endtask

  task automatic t_hold();
    logic [31:0] v;
    logic [7:0]  ops [3];
    int r0;
    ops[0] = 8'h9F; ops[1] = 8'h00; ops[2] = 8'hC3;
    seed = 8'h2C;
    for (int k = 0; k < 3; k++) begin
      r0 = rises;
      reg_write(4'h0, ctrl_word(1'b1, 1'b1, 3'd5, ops[k]));
      wait_idle("R8");
      chk($sformatf("R8 cs held after byte%0d", k), {31'd0, spi_cs_n}, 32'd0);
      chk($sformatf("R8 one byte per txn %0d", k), 32'(rises - r0), 32'd8);
      chk($sformatf("R8 mosi byte%0d", k), {24'd0, mosi_log[k]}, {24'd0, ops[k]});
      reg_read(4'h8, v);
      chk($sformatf("R8 result byte%0d", k), v, {24'd0, pat(k, 8'h2C)});
    end
    reg_read(4'h0, v);
    chk("R1 ctrl hold bit", v, ctrl_word(1'b0, 1'b1, 3'd5, 8'hC3));
    reg_write(4'h0, ctrl_word(1'b0, 1'b1, 3'd0, 8'h00));
    chk("R9 hold-set write keeps cs", {31'd0, spi_cs_n}, 32'd0);
    reg_write(4'h0, ctrl_word(1'b0, 1'b0, 3'd0, 8'h00));
    chk("R9 release write drives cs high", {31'd0, spi_cs_n}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    for (int a = 0; a < 8; a++)
      t_select(a, 8'h03 + 8'(a) * 8'h10, 32'hAB00_0000 | (32'h0001_0203 * (a + 1)), 8'(a * 29 + 5));
    t_busy_writes();
    t_hold();
    chk("R3 sck period within frames", 32'(period_err), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end
endmodule